// File: doc/BRIEF.md
# Watchdog Timeout Controller

This block is a watchdog for a system controller. A down-counter is loaded from an external timeout value and decremented on a derived timebase. When it runs out, a sticky timeout status flag is set. Software can also raise the flag with a self-clearing force bit. A third source is a rising edge on a keyboard-reset input pin, which passes through a glitch filter of about 1 µs before its edge is detected. Mouse and keyboard interrupt pulses can each be enabled to restart the count, so that user activity keeps the timer from expiring.

The block also drives a power LED output that blinks at 1 Hz with equal high and low time. The blink runs when software requests it directly. It can also be set to run only while a timeout is pending. Two byte-wide control registers are written and read through a simple one-bit-addressed register port.

Top module: `wdt_guard`

## Requirements
- R1: After reset both control registers read 0x00, the status output is 0 and the LED output is 0.
- R2: Bits 7..4 of both registers and bit 0 of register 0 read as 0. Bit 2 of register 1 is write-only and reads as 0. Register 0 (address 0) holds the LED-on-timeout enable in bit 3, the mouse restart enable in bit 2 and the keyboard restart enable in bit 1. Register 1 (address 1) holds the pin trigger enable in bit 3, the force bit in bit 2, the blink enable in bit 1 and the status in bit 0.
- R3: While register 0 bit 2 is 1, a one-cycle pulse on mouseIrq reloads the count from loadVal. While that bit is 0, mouseIrq has no effect on the count.
- R4: While register 0 bit 1 is 1, a one-cycle pulse on kbdIrq reloads the count from loadVal. While that bit is 0, kbdIrq has no effect on the count.
- R5: Every write to register 1 reloads the count from loadVal. A nonzero count decrements once every TICK_CYCLES clocks. When it reaches zero, status is set and counting stops. A loadVal of 0 never sets status.
- R6: Writing register 1 with bit 2 equal to 1 sets status on the next clock edge. The force bit reads back as 0.
- R7: While register 1 bit 3 is 1, a rising edge of the filtered kbdRstPin sets status. While that bit is 0, the pin has no effect.
- R8: The filter passes a level on kbdRstPin only after it has been stable for DEB_CYCLES clocks, so shorter pulses are rejected.
- R9: Status is readable as register 1 bit 0. Status stays set until software writes register 1 with bit 0 equal to 0. A set event in the same cycle takes precedence over the clear.
- R10: powerLed is a square wave with BLINK_HALF clocks high and BLINK_HALF clocks low whenever register 1 bit 1 is 1, or when register 0 bit 3 is 1 and status is 1. Otherwise powerLed is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select (0 or 1) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| loadVal | input | CNT_W | Timeout count in ticks |
| mouseIrq | input | 1 | Mouse interrupt pulse |
| kbdIrq | input | 1 | Keyboard interrupt pulse |
| kbdRstPin | input | 1 | Asynchronous keyboard-reset pin |
| toStatus | output | 1 | Timeout status flag |
| powerLed | output | 1 | Power LED drive |

## Verification
The assertions check the following on every cycle:
- Reserved and write-only bits always read as zero.
- A force write always raises status on the following edge.
- Status never drops except through a software clear.
- The LED is dark one cycle after both blink conditions go away.

Only the bench scenarios can show the following:
- The exact expiry time after a kick.
- That an enabled interrupt pulse restarts the count while a disabled one does not.
- That short pin glitches are rejected while long pulses trigger.
- The 50% duty cycle of the blink.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic restart;
    logic forceTo;
    logic statWr;
    logic statVal;
  } wdt_strb_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regAddr,
  input  logic [7:0] regWrData,
  input  logic       mouseIrq,
  input  logic       kbdIrq,
  input  logic       toStatus,
  output logic [7:0] regRdData,
  output wdt_strb_t  strb,
  output logic       ledOnTo,
  output logic       blinkForce,
  output logic       pinTrigEn
);
  logic mouseEn, kbdEn;
  logic wr0, wr1;
  logic unusedBits;

  assign wr0 = regWr & ~regAddr;
  assign wr1 = regWr & regAddr;
  assign unusedBits = ^regWrData[7:4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledOnTo    <= 1'b0;
      mouseEn    <= 1'b0;
      kbdEn      <= 1'b0;
      pinTrigEn  <= 1'b0;
      blinkForce <= 1'b0;
    end else begin
      if (wr0) begin
        ledOnTo <= regWrData[3];
        mouseEn <= regWrData[2];
        kbdEn   <= regWrData[1];
      end
      if (wr1) begin
        pinTrigEn  <= regWrData[3];
        blinkForce <= regWrData[1];
      end
    end
  end

  always_comb begin
    strb.restart = (mouseIrq & mouseEn) | (kbdIrq & kbdEn) | wr1;
    strb.forceTo = wr1 & regWrData[2];
    strb.statWr  = wr1;
    strb.statVal = regWrData[0];
    if (regAddr)
      regRdData = {4'h0, pinTrigEn, 1'b0, blinkForce, toStatus};
    else
      regRdData = {4'h0, ledOnTo, mouseEn, kbdEn, 1'b0};
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TICK_CYCLES = 1000,
  parameter int DEB_CYCLES  = 50,
  parameter int BLINK_HALF  = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdt_strb_t        strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             kbdRstPin,
  input  logic             pinTrigEn,
  input  logic             ledOnTo,
  input  logic             blinkForce,
  output logic             toStatus,
  output logic             powerLed
);
  localparam int TICK_N = (TICK_CYCLES < 1) ? 1 : TICK_CYCLES;
  localparam int DEB_N  = (DEB_CYCLES < 1) ? 1 : DEB_CYCLES;
  localparam int BLK_N  = (BLINK_HALF < 1) ? 1 : BLINK_HALF;
  localparam int PRE_W  = $clog2(TICK_N + 1);
  localparam int DEB_W  = $clog2(DEB_N + 1);
  localparam int BLK_W  = $clog2(BLK_N + 1);

  logic [CNT_W-1:0] cntQ;
  logic [PRE_W-1:0] preQ;
  logic             tick, expire;

  assign tick   = (cntQ != '0) && (preQ == PRE_W'(TICK_N - 1));
  assign expire = tick && (cntQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      preQ <= '0;
    end else if (strb.restart) begin
      cntQ <= loadVal;
      preQ <= '0;
    end else if (cntQ != '0) begin
      if (tick) begin
        preQ <= '0;
        cntQ <= cntQ - CNT_W'(1);
      end else begin
        preQ <= preQ + PRE_W'(1);
      end
    end
  end

  // pin synchroniser and glitch filter
  logic [1:0]       syncQ;
  logic             filtQ, filtPrevQ;
  logic [DEB_W-1:0] debQ;
  logic             pinEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= '0;
      filtQ     <= 1'b0;
      filtPrevQ <= 1'b0;
      debQ      <= '0;
    end else begin
      syncQ     <= {syncQ[0], kbdRstPin};
      filtPrevQ <= filtQ;
      if (syncQ[1] == filtQ) begin
        debQ <= '0;
      end else if (debQ == DEB_W'(DEB_N - 1)) begin
        debQ  <= '0;
        filtQ <= syncQ[1];
      end else begin
        debQ <= debQ + DEB_W'(1);
      end
    end
  end

  assign pinEdge = pinTrigEn & filtQ & ~filtPrevQ;

  // status flag: set events win over a software write
  always_ff @(posedge clk) begin
    if (!rstN)
      toStatus <= 1'b0;
    else if (strb.forceTo | pinEdge | expire)
      toStatus <= 1'b1;
    else if (strb.statWr)
      toStatus <= strb.statVal;
  end

  // LED blink generator
  logic             blinkOn;
  logic [BLK_W-1:0] blkQ;

  assign blinkOn = blinkForce | (ledOnTo & toStatus);

  always_ff @(posedge clk) begin
    if (!rstN || !blinkOn) begin
      blkQ     <= '0;
      powerLed <= 1'b0;
    end else if (blkQ == BLK_W'(BLK_N - 1)) begin
      blkQ     <= '0;
      powerLed <= ~powerLed;
    end else begin
      blkQ <= blkQ + BLK_W'(1);
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int CNT_W       = 8,
  parameter int TICK_CYCLES = CLK_HZ / 1000,
  parameter int DEB_CYCLES  = CLK_HZ / 1_000_000,
  parameter int BLINK_HALF  = CLK_HZ / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             mouseIrq,
  input  logic             kbdIrq,
  input  logic             kbdRstPin,
  output logic             toStatus,
  output logic             powerLed
);
  wdt_strb_t strb;
  logic      ledOnTo, blinkForce, pinTrigEn;

  wdt_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .mouseIrq(mouseIrq), .kbdIrq(kbdIrq),
    .toStatus(toStatus), .regRdData(regRdData), .strb(strb),
    .ledOnTo(ledOnTo), .blinkForce(blinkForce), .pinTrigEn(pinTrigEn)
  );

  wdt_datapath #(
    .CNT_W(CNT_W), .TICK_CYCLES(TICK_CYCLES),
    .DEB_CYCLES(DEB_CYCLES), .BLINK_HALF(BLINK_HALF)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .kbdRstPin(kbdRstPin), .pinTrigEn(pinTrigEn), .ledOnTo(ledOnTo),
    .blinkForce(blinkForce), .toStatus(toStatus), .powerLed(powerLed)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic       regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       toStatus,
  input logic       powerLed,
  input logic       ledOnTo,
  input logic       blinkForce
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[7:4] == 4'h0) && (regAddr ? !regRdData[2] : !regRdData[0]));

  a_r6_force_sets: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr && regWrData[2]) |=> toStatus);

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (toStatus && !(regWr && regAddr && !regWrData[0])) |=> toStatus);

  a_r10_led_dark: assert property (@(posedge clk) disable iff (!rstN)
    (!blinkForce && !(ledOnTo && toStatus)) |=> !powerLed);
endmodule

bind wdt_guard wdt_guard_chk chkI (.*);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 4;
  localparam int HALF  = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0, regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00, regRdData;
  logic [7:0] loadVal = 8'h00;
  logic       mouseIrq = 1'b0, kbdIrq = 1'b0, kbdRstPin = 1'b0;
  logic       toStatus, powerLed;
  int         nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard #(.CNT_W(8), .TICK_CYCLES(TICKS), .DEB_CYCLES(5), .BLINK_HALF(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .loadVal(loadVal),
    .mouseIrq(mouseIrq), .kbdIrq(kbdIrq), .kbdRstPin(kbdRstPin),
    .toStatus(toStatus), .powerLed(powerLed)
  );

  // {addr, write data, expected readback}
  localparam logic [16:0] VEC [7] = '{
    {1'b0, 8'hFF, 8'h0E}, {1'b0, 8'h04, 8'h04}, {1'b0, 8'h0A, 8'h0A},
    {1'b0, 8'h00, 8'h00}, {1'b1, 8'hF2, 8'h02}, {1'b1, 8'h08, 8'h08},
    {1'b1, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = 8'h00;
  endtask

  task automatic regRead(input logic a, output logic [7:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic pulseMouse();
    mouseIrq = 1'b1; @(negedge clk); mouseIrq = 1'b0;
  endtask

  task automatic pulseKbd();
    kbdIrq = 1'b1; @(negedge clk); kbdIrq = 1'b0;
  endtask

  task automatic countHigh(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (powerLed) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int hi;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    regRead(1'b0, rd); check("R1 reg0", rd, 0);
    regRead(1'b1, rd); check("R1 reg1", rd, 0);
    check("R1 status", toStatus, 0);
    check("R1 led", powerLed, 0);

    // R2 readback vectors
    for (int i = 0; i < 7; i++) begin
      regWrite(VEC[i][16], VEC[i][15:8]);
      regRead(VEC[i][16], rd);
      check("R2 readback", rd, VEC[i][7:0]);
    end

    // R6 force and write-only bit
    regWrite(1'b1, 8'h04);
    check("R6 force sets status", toStatus, 1);
    regRead(1'b1, rd); check("R6 force reads zero", rd, 8'h01);
    // R9 software clear
    regWrite(1'b1, 8'h00);
    check("R9 clear", toStatus, 0);

    // R5 expiry
    loadVal = 8'd3;
    regWrite(1'b1, 8'h00);
    waitN(10); check("R5 before expiry", toStatus, 0);
    waitN(4);  check("R5 after expiry", toStatus, 1);
    regRead(1'b1, rd); check("R9 status readable", rd, 8'h01);
    waitN(5);  check("R9 sticky", toStatus, 1);

    // R3 mouse restart enabled
    regWrite(1'b0, 8'h04);
    regWrite(1'b1, 8'h00);
    waitN(8); pulseMouse();
    waitN(9); check("R3 mouse restarts", toStatus, 0);
    waitN(4); check("R3 expiry after restart", toStatus, 1);
    // R3 mouse disabled
    regWrite(1'b0, 8'h00);
    regWrite(1'b1, 8'h00);
    waitN(8); pulseMouse();
    waitN(9); check("R3 mouse ignored", toStatus, 1);

    // R4 keyboard restart
    regWrite(1'b0, 8'h02);
    regWrite(1'b1, 8'h00);
    waitN(8); pulseKbd();
    waitN(9); check("R4 kbd restarts", toStatus, 0);
    regWrite(1'b0, 8'h00);
    regWrite(1'b1, 8'h00);
    waitN(8); pulseKbd();
    waitN(9); check("R4 kbd ignored", toStatus, 1);

    // R5 zero load
    loadVal = 8'd0;
    regWrite(1'b1, 8'h00);
    waitN(40); check("R5 zero load idle", toStatus, 0);

    // R7 / R8 pin trigger
    regWrite(1'b1, 8'h08);
    kbdRstPin = 1'b1; waitN(3); kbdRstPin = 1'b0;
    waitN(20); check("R8 short pulse rejected", toStatus, 0);
    kbdRstPin = 1'b1; waitN(20);
    check("R7 pin edge sets", toStatus, 1);
    kbdRstPin = 1'b0; waitN(20);
    regWrite(1'b1, 8'h00);
    kbdRstPin = 1'b1; waitN(20);
    check("R7 pin disabled", toStatus, 0);
    kbdRstPin = 1'b0; waitN(20);

    // R10 blink
    regWrite(1'b1, 8'h02);
    waitN(5); countHigh(60, hi); check("R10 forced blink duty", hi, 30);
    regWrite(1'b1, 8'h00);
    regWrite(1'b0, 8'h08);
    countHigh(40, hi); check("R10 no timeout dark", hi, 0);
    regWrite(1'b1, 8'h04);
    waitN(3); countHigh(40, hi); check("R10 timeout blink", hi, 20);
    regWrite(1'b1, 8'h00);
    waitN(2); countHigh(20, hi); check("R10 off after clear", hi, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule